// File: doc/BRIEF.md
# Horizontal Video Decimation Filter

This block shrinks a digitised video line horizontally for a picture-in-picture path. Luma arrives as 6-bit unsigned samples at the full pixel rate; the two colour-difference components arrive as 6-bit two's-complement samples on a separate strobe at one quarter of that rate. Inside a window that opens a programmable distance after horizontal sync, each lane sums groups of 3 or 4 consecutive samples through a short FIR kernel. It then normalises the sum and emits one reduced sample per group.

The factor select picks 3:1 or 4:1 reduction, and the window length follows from it. A delay code slides the window to centre the picture. A line-standard flag together with the incoming field-line number decides whether the current line lies in the active picture. Colour samples can be negated on entry to fix input polarity. A double-gain mode doubles the colour result for sources that carry colour only on alternate lines. Outputs carry their own one-cycle valid strobes and a flag that marks the open window.

Top module: `pip_hdec`

## Requirements
- R1: Luma strobes after `hsync_i` are numbered from 0; strobes in the same cycle as `hsync_i` are not counted. The window opens at index 104 + 6·`hdel_i`. `line_active_o` is 1 from the cycle after the first in-window sample until the cycle after the last one, and `hsync_i` clears it. After reset no window opens until the first `hsync_i`.
- R2: The window spans 636 luma samples when `dec4_i`=0 (3:1) and 640 when `dec4_i`=1 (4:1). This gives at most 212 or 160 luma outputs and at most 53 or 40 colour outputs per line.
- R3: The window opens only on lines where `line_i` ≥ 36 with `std625_i`=1, or `line_i` ≥ 26 with `std625_i`=0. On other lines there is no output and `line_active_o` stays 0.
- R4: At 3:1 each luma output is (a+b+c)/3, truncated, over three consecutive in-window luma samples.
- R5: At 3:1 each colour output is (a+2b+c)/4, rounded toward zero, over three consecutive in-window colour samples, where b is the middle one.
- R6: At 4:1 both luma and colour outputs are (a+b+c+d)/4 over four consecutive samples, rounded toward zero.
- R7: With `chroma_inv_i`=1 each colour input is negated before filtering, and -32 becomes +31.
- R8: With `dbl_gain_i`=1 the normalised colour result is doubled and then saturated to [-32, 31]. Luma is not affected.
- R9: Luma groups start with the first in-window sample. Colour groups start with the first colour strobe inside the window. Each output appears, with its valid strobe high for one cycle, one clock after the strobe that completes its group. `chroma_valid_i` is only high together with `luma_valid_i`.
- R10: No output is produced outside the window, and an incomplete group at the window's end is dropped.
- R11: During reset all data outputs are 0 and all strobes and `line_active_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync pulse |
| luma_valid_i | input | 1 | Luma sample strobe |
| luma_i | input | 6 | Luma sample, unsigned |
| chroma_valid_i | input | 1 | Colour sample strobe (quarter rate) |
| chroma_u_i | input | 6 | Blue-difference sample, signed |
| chroma_v_i | input | 6 | Red-difference sample, signed |
| std625_i | input | 1 | 1: 625-line standard, 0: 525-line |
| line_i | input | 10 | Current field-line number |
| dec4_i | input | 1 | 0: 3:1 reduction, 1: 4:1 reduction |
| hdel_i | input | 4 | Window delay code, 6 samples per step |
| chroma_inv_i | input | 1 | Negate colour inputs |
| dbl_gain_i | input | 1 | Double colour output gain |
| luma_o | output | 6 | Decimated luma |
| luma_valid_o | output | 1 | Luma output strobe |
| chroma_u_o | output | 6 | Decimated blue-difference |
| chroma_v_o | output | 6 | Decimated red-difference |
| chroma_valid_o | output | 1 | Colour output strobe |
| line_active_o | output | 1 | Decimation window open |

## Verification
The assertions assume that a colour strobe never arrives without a luma strobe. They also assume that the mode inputs (factor, delay, standard, line, polarity, gain) are held steady from sync until the window closes, and that sync never coincides with a sample strobe. The stimulus sets every mode input before the sync pulse and holds it for the whole line. It raises colour strobes only on luma-strobe cycles, with a chosen phase offset, and leaves the sync cycle free of samples. Idle cycles are inserted between samples on some lines, but never as a pulse on the colour strobe alone.

// File: rtl/pip_hdec_pkg.sv
`timescale 1ns/1ps
package pip_hdec_pkg;
  localparam int CHROMA_DIV = 4;  // colour strobe rate divider vs luma

  function automatic int grp_cap(input int win_len, input int grp, input int div);
    return win_len / (grp * div);
  endfunction
endpackage

// File: rtl/pip_hdec_window.sv
`timescale 1ns/1ps
module pip_hdec_window #(
  parameter int POS_W    = 11,
  parameter int LINE_W   = 10,
  parameter int HD_W     = 4,
  parameter int BASE     = 104,
  parameter int STEP     = 6,
  parameter int LEN3     = 636,
  parameter int LEN4     = 640,
  parameter int FIRST_A  = 36,
  parameter int FIRST_B  = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              valid_i,
  input  logic              std625_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              dec4_i,
  input  logic [HD_W-1:0]   hdel_i,
  output logic              in_win_o,
  output logic              first_o,
  output logic              active_o
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q, start_c, stop_c;
  logic             line_ok, take, last_c;

  assign start_c = POS_W'(BASE) + POS_W'(STEP) * POS_W'(hdel_i);
  assign stop_c  = start_c + (dec4_i ? POS_W'(LEN4) : POS_W'(LEN3));
  assign line_ok = line_i >= (std625_i ? LINE_W'(FIRST_A) : LINE_W'(FIRST_B));
  assign take    = valid_i && !hsync_i && line_ok;
  assign first_o = take && (pos_q == start_c);
  assign in_win_o = take && (pos_q >= start_c) && (pos_q < stop_c);
  assign last_c  = in_win_o && (pos_q == stop_c - POS_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= POS_MAX;
      active_o <= 1'b0;
    end else if (hsync_i) begin
      pos_q    <= '0;
      active_o <= 1'b0;
    end else begin
      if (valid_i && pos_q != POS_MAX) pos_q <= pos_q + POS_W'(1);
      if (first_o)     active_o <= 1'b1;
      else if (last_c) active_o <= 1'b0;
    end
  end

  assert_active_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(valid_i && !hsync_i));
  assert_sync_closes_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_i |=> !active_o);
endmodule

// File: rtl/pip_hdec_lane.sv
`timescale 1ns/1ps
module pip_hdec_lane #(
  parameter int W         = 6,
  parameter int NCOMP     = 1,
  parameter bit IS_CHROMA = 1'b0,
  parameter int CAP3      = 212,
  parameter int CAP4      = 160
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               strobe_i,
  input  logic               dec4_i,
  input  logic               invert_i,
  input  logic               gain_i,
  input  logic [NCOMP*W-1:0] data_i,
  output logic [NCOMP*W-1:0] data_o,
  output logic               valid_o
);
  localparam int ACC_W = W + 4;
  localparam int CNT_W = $clog2((CAP3 > CAP4 ? CAP3 : CAP4) + 1);
  localparam logic signed [ACC_W-1:0] DIV3 = ACC_W'(3);
  localparam logic signed [ACC_W-1:0] DIV4 = ACC_W'(4);
  localparam logic signed [ACC_W-1:0] HI =
    IS_CHROMA ? ACC_W'((2 ** (W - 1)) - 1) : ACC_W'((2 ** W) - 1);
  localparam logic signed [ACC_W-1:0] LO =
    IS_CHROMA ? ACC_W'(-(2 ** (W - 1))) : ACC_W'(0);

  logic [1:0]       ph_q, ph_c, last_ph;
  logic [CNT_W-1:0] cnt_q, cnt_c;
  logic             done_c, emit_c, mid_tap;

  assign last_ph = dec4_i ? 2'd3 : 2'd2;
  assign ph_c    = restart_i ? 2'd0 : ph_q;
  assign cnt_c   = restart_i ? '0 : cnt_q;
  assign done_c  = strobe_i && (ph_c == last_ph);
  assign emit_c  = done_c && (cnt_c < (dec4_i ? CNT_W'(CAP4) : CNT_W'(CAP3)));
  assign mid_tap = IS_CHROMA && !dec4_i && (ph_c == 2'd1);  // 1-2-1 centre tap

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= '0;
      cnt_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= emit_c;
      cnt_q   <= cnt_c + CNT_W'(emit_c);
      if (strobe_i)       ph_q <= done_c ? 2'd0 : ph_c + 2'd1;
      else if (restart_i) ph_q <= 2'd0;
    end
  end

  for (genvar k = 0; k < NCOMP; k++) begin : g_comp
    logic [W-1:0]             raw, dq, res;
    logic signed [ACC_W-1:0]  x, acc_q, acc_nxt, quot, scaled;

    assign raw = data_i[k*W +: W];

    if (IS_CHROMA) begin : g_sgn
      logic signed [ACC_W-1:0] ext;
      assign ext = ACC_W'($signed(raw));
      always_comb begin
        x = invert_i ? -ext : ext;
        if (x > HI) x = HI;
      end
    end else begin : g_uns
      logic unused_inv;
      assign unused_inv = invert_i;
      assign x = ACC_W'({1'b0, raw});
    end

    assign acc_nxt = ((ph_c == 2'd0) ? '0 : acc_q) + (mid_tap ? (x <<< 1) : x);
    assign quot    = acc_nxt / ((dec4_i || IS_CHROMA) ? DIV4 : DIV3);
    assign scaled  = (IS_CHROMA && gain_i) ? (quot <<< 1) : quot;
    assign res     = W'((scaled > HI) ? HI : ((scaled < LO) ? LO : scaled));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q <= '0;
        dq    <= '0;
      end else begin
        if (strobe_i) acc_q <= acc_nxt;
        if (emit_c)   dq    <= res;
      end
    end

    assign data_o[k*W +: W] = dq;
  end

  assert_emit_follows_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(strobe_i));
  assert_count_advances_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cnt_q != '0);
endmodule

// File: rtl/pip_hdec.sv
`timescale 1ns/1ps
module pip_hdec
  import pip_hdec_pkg::*;
#(
  parameter int W        = 6,
  parameter int LINE_W   = 10,
  parameter int HD_W     = 4,
  parameter int POS_W    = 11,
  parameter int WIN_BASE = 104,
  parameter int WIN_STEP = 6,
  parameter int LEN3     = 636,
  parameter int LEN4     = 640,
  parameter int FIRST625 = 36,
  parameter int FIRST525 = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              luma_valid_i,
  input  logic [W-1:0]      luma_i,
  input  logic              chroma_valid_i,
  input  logic [W-1:0]      chroma_u_i,
  input  logic [W-1:0]      chroma_v_i,
  input  logic              std625_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              dec4_i,
  input  logic [HD_W-1:0]   hdel_i,
  input  logic              chroma_inv_i,
  input  logic              dbl_gain_i,
  output logic [W-1:0]      luma_o,
  output logic              luma_valid_o,
  output logic [W-1:0]      chroma_u_o,
  output logic [W-1:0]      chroma_v_o,
  output logic              chroma_valid_o,
  output logic              line_active_o
);
  localparam int Y_CAP3 = grp_cap(LEN3, 3, 1);
  localparam int Y_CAP4 = grp_cap(LEN4, 4, 1);
  localparam int C_CAP3 = grp_cap(LEN3, 3, CHROMA_DIV);
  localparam int C_CAP4 = grp_cap(LEN4, 4, CHROMA_DIV);

  logic in_win, win_first;

  pip_hdec_window #(
    .POS_W(POS_W), .LINE_W(LINE_W), .HD_W(HD_W), .BASE(WIN_BASE), .STEP(WIN_STEP),
    .LEN3(LEN3), .LEN4(LEN4), .FIRST_A(FIRST625), .FIRST_B(FIRST525)
  ) u_win (
    .clk_i, .rst_ni, .hsync_i, .valid_i(luma_valid_i), .std625_i, .line_i,
    .dec4_i, .hdel_i, .in_win_o(in_win), .first_o(win_first), .active_o(line_active_o)
  );

  pip_hdec_lane #(.W(W), .NCOMP(1), .IS_CHROMA(1'b0), .CAP3(Y_CAP3), .CAP4(Y_CAP4)) u_luma (
    .clk_i, .rst_ni, .restart_i(win_first), .strobe_i(in_win), .dec4_i,
    .invert_i(1'b0), .gain_i(1'b0), .data_i(luma_i), .data_o(luma_o), .valid_o(luma_valid_o)
  );

  pip_hdec_lane #(.W(W), .NCOMP(2), .IS_CHROMA(1'b1), .CAP3(C_CAP3), .CAP4(C_CAP4)) u_chroma (
    .clk_i, .rst_ni, .restart_i(win_first), .strobe_i(in_win && chroma_valid_i), .dec4_i,
    .invert_i(chroma_inv_i), .gain_i(dbl_gain_i), .data_i({chroma_v_i, chroma_u_i}),
    .data_o({chroma_v_o, chroma_u_o}), .valid_o(chroma_valid_o)
  );

  assert_luma_in_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    luma_valid_o |-> $past(line_active_o));
  assert_chroma_in_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chroma_valid_o |-> $past(line_active_o));
  assert_chroma_aligned_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chroma_valid_i |-> luma_valid_i);
endmodule

// File: tb/pip_hdec_test.sv
`timescale 1ns/1ps
module pip_hdec_test;
  localparam int NS = 900;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_ni = 1'b0, hsync = 1'b0, lv = 1'b0, cv = 1'b0;
  logic [5:0] y_in = '0, u_in = '0, v_in = '0;
  logic       std625 = 1'b1, dec4 = 1'b0, cinv = 1'b0, gain = 1'b0;
  logic [9:0] line = '0;
  logic [3:0] hdel = '0;
  logic [5:0] y_o, u_o, v_o;
  logic       yv_o, cv_o, act_o;

  pip_hdec uut (
    .clk_i(clk), .rst_ni, .hsync_i(hsync), .luma_valid_i(lv), .luma_i(y_in),
    .chroma_valid_i(cv), .chroma_u_i(u_in), .chroma_v_i(v_in), .std625_i(std625),
    .line_i(line), .dec4_i(dec4), .hdel_i(hdel), .chroma_inv_i(cinv), .dbl_gain_i(gain),
    .luma_o(y_o), .luma_valid_o(yv_o), .chroma_u_o(u_o), .chroma_v_o(v_o),
    .chroma_valid_o(cv_o), .line_active_o(act_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int    exp_y[$], exp_u[$], exp_v[$];
  string tag_y[$], tag_c[$];
  logic [5:0] sy[NS], su[NS], sv[NS];
  bit         sc[NS];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int cval(logic [5:0] raw, bit inv);
    int x = int'($signed(raw));
    if (inv) x = -x;
    if (x > 31) x = 31;
    return x;
  endfunction

  function automatic int csat(int q, bit g);
    int r = g ? q * 2 : q;
    if (r > 31) r = 31;
    if (r < -32) r = -32;
    return r;
  endfunction

  // monitor: pop expected items as outputs appear
  int e, eu, ev;
  string t;
  always @(negedge clk) if (rst_ni && !done) begin
    if (yv_o) begin
      if (exp_y.size() == 0) check(0, "R10", "unexpected luma", int'(y_o), -1);
      else begin
        e = exp_y.pop_front(); t = tag_y.pop_front();
        check(int'(y_o) == e, t, "luma", int'(y_o), e);
      end
    end
    if (cv_o) begin
      if (exp_u.size() == 0) check(0, "R10", "unexpected chroma", int'($signed(u_o)), -99);
      else begin
        eu = exp_u.pop_front(); ev = exp_v.pop_front(); t = tag_c.pop_front();
        check(int'($signed(u_o)) == eu, t, "chroma u", int'($signed(u_o)), eu);
        check(int'($signed(v_o)) == ev, t, "chroma v", int'($signed(v_o)), ev);
      end
    end
  end

  task automatic run_line(bit d4, int hd, bit s625, int ln, bit inv, bit gn,
                          int seed, int coff, bit gaps);
    int  st  = 104 + 6 * hd;
    int  len = d4 ? 640 : 636;
    int  n   = d4 ? 4 : 3;
    int  cap = d4 ? 40 : 53;
    bit  ok  = ln >= (s625 ? 36 : 26);
    int  cidx[$];
    string ctag;
    for (int k = 0; k < NS; k++) begin
      if (seed == 0) begin
        sy[k] = 6'd63; su[k] = 6'h20; sv[k] = 6'h1f;
      end else begin
        sy[k] = 6'((k * 7 + seed * 13 + (k >> 3)) & 63);
        su[k] = 6'(((k * 5 + seed * 29) ^ (k >> 2)) & 63);
        sv[k] = 6'((k * 11 + seed * 3 + (k >> 4)) & 63);
      end
      sc[k] = (k % 4) == coff;
    end
    ctag = d4 ? "R6" : "R5";
    if (inv) ctag = {ctag, "/R7"};
    if (gn)  ctag = {ctag, "/R8"};
    if (ok) begin
      for (int g = 0; g < len / n; g++) begin
        int s = 0;
        for (int j = 0; j < n; j++) s += int'(sy[st + g * n + j]);
        exp_y.push_back(s / n);
        tag_y.push_back(d4 ? "R6" : "R4");
      end
      for (int k = st; k < st + len; k++) if (sc[k]) cidx.push_back(k);
      for (int g = 0; g < cidx.size() / n && g < cap; g++) begin
        int a = 0, b = 0;
        for (int j = 0; j < n; j++) begin
          int w = (!d4 && j == 1) ? 2 : 1;
          a += w * cval(su[cidx[g * n + j]], inv);
          b += w * cval(sv[cidx[g * n + j]], inv);
        end
        exp_u.push_back(csat(a / 4, gn));
        exp_v.push_back(csat(b / 4, gn));
        tag_c.push_back(ctag);
      end
    end
    dec4 = d4; hdel = 4'(hd); std625 = s625; line = 10'(ln); cinv = inv; gain = gn;
    @(posedge clk); #1 hsync = 1'b1; lv = 1'b0; cv = 1'b0;
    @(posedge clk); #1 hsync = 1'b0;
    for (int k = 0; k < NS; k++) begin
      @(posedge clk); #1;
      if (gaps && (k % 5) == 4) begin
        lv = 1'b0; cv = 1'b0;
        @(posedge clk); #1;
      end
      if (k - 1 == st - 1) check(act_o == 1'b0, "R1", "active before window", int'(act_o), 0);
      if (k - 1 == st)     check(act_o == ok, ok ? "R1" : "R3", "active at window start",
                                 int'(act_o), int'(ok));
      if (k - 1 == st + len - 1) check(act_o == 1'b0, "R2", "active after window end",
                                       int'(act_o), 0);
      lv = 1'b1; y_in = sy[k]; cv = sc[k]; u_in = su[k]; v_in = sv[k];
    end
    @(posedge clk); #1 lv = 1'b0; cv = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    check(exp_y.size() == 0, "R2/R10", "luma items outstanding", exp_y.size(), 0);
    check(exp_u.size() == 0, "R2/R9", "chroma items outstanding", exp_u.size(), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check(y_o == 0 && u_o == 0 && v_o == 0, "R11", "data in reset", int'(y_o), 0);
    check(!yv_o && !cv_o && !act_o, "R11", "strobes in reset", int'(yv_o | cv_o | act_o), 0);
    rst_ni = 1'b1;
    // no window before first sync
    for (int k = 0; k < 300; k++) begin
      @(posedge clk); #1 lv = 1'b1; cv = (k % 4) == 0; line = 10'd100;
    end
    @(posedge clk); #1 lv = 1'b0; cv = 1'b0;
    check(act_o == 1'b0, "R1", "active without sync", int'(act_o), 0);
    run_line(0, 0,  1, 40,  0, 0, 1, 0, 0);  // R4 R5 basic 3:1
    run_line(1, 5,  0, 30,  1, 0, 2, 1, 0);  // R6 R7 4:1
    run_line(0, 15, 1, 35,  0, 0, 3, 0, 0);  // R3 line too early
    run_line(0, 0,  0, 26,  0, 0, 5, 3, 1);  // R3 boundary, R9 offset, gaps
    run_line(0, 2,  1, 36,  1, 1, 0, 2, 0);  // R7 R8 extremes
    run_line(1, 9,  1, 200, 0, 1, 3, 2, 1);  // R6 R8 gaps
    run_line(0, 7,  0, 150, 0, 1, 4, 1, 1);  // R5 R8 R9
    run_line(1, 15, 0, 99,  0, 1, 0, 3, 0);  // R6 R8 low saturation, max delay
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule